// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Sticky Error Status

This block buffers audio samples in both directions between a memory-side transfer engine and a serial audio link. Samples to be sent are written by the memory side and taken by the link each time it asks for a slot. Samples that arrive from the link are queued and read back by the memory side. Each direction holds up to sixteen 32-bit samples.

The block defines what happens when the link runs ahead of the memory side. If the link asks for a sample and none is queued, the last sample sent goes out again and the queue does not move. If the link delivers a sample and the receive queue is full, that sample is dropped. Each of these events sets a sticky error flag. Software reads these flags through a small 32-bit register port and clears a flag by writing a 1 to its bit.

The memory side can check the full and empty outputs to pace its transfers. Overfilling the transmit queue, or reading an empty receive queue, is handled quietly and does not set an error flag.

Top module: `audio_fifo_pair`

## Requirements
- R1: After synchronous reset, both status registers read 0, `link_tx_data` and `rx_rd_data` are 0, `tx_full` is 0 and `rx_empty` is 1.
- R2: Samples written with `tx_wr_en` leave on `link_tx_data` in the order they were written, one per `link_tx_req`. The new value appears on the clock edge that follows the request.
- R3: A `link_tx_req` while the transmit queue is empty sets the transmit error flag (bit 4 of the register at offset 0x10) one cycle later. `link_tx_data` keeps the last sample sent, or 0 if nothing has been sent yet. The queue is left as it was, so samples written later still come out in order.
- R4: Samples delivered with `link_rx_valid` are returned on `rx_rd_data` in arrival order, one per `rx_rd_en`. The new value appears on the edge that follows the read.
- R5: A `link_rx_valid` while the receive queue holds 16 samples sets the receive error flag (bit 4 of the register at offset 0x14) one cycle later. The incoming sample is discarded and the queued samples are unchanged. This holds even if a read takes place in the same cycle.
- R6: A register write to offset 0x10 or 0x14 with `reg_wdata[4]`=1 clears that register's flag. A write with bit 4 = 0, or a write to any other offset, leaves both flags unchanged.
- R7: If an error event and a clearing write to the same flag happen in the same cycle, the flag ends up set.
- R8: `reg_rdata` follows `reg_addr` combinationally. At 0x10 and 0x14 it returns the flag in bit 4 and 0 in every other bit. At any other offset it returns 0.
- R9: A `tx_wr_en` while the transmit queue holds 16 samples is ignored and sets no flag.
- R10: An `rx_rd_en` while the receive queue is empty leaves `rx_rd_data` unchanged and sets no flag.
- R11: Each queue holds exactly 16 samples. `tx_full` rises after the 16th accepted write. `rx_empty` is 1 exactly when no received sample is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_en | input | 1 | Memory-side write strobe for the transmit queue |
| tx_wr_data | input | 32 | Sample to queue for transmission |
| tx_full | output | 1 | Transmit queue holds 16 samples |
| link_tx_req | input | 1 | Link asks for the next transmit sample |
| link_tx_data | output | 32 | Sample most recently handed to the link |
| link_rx_valid | input | 1 | Link delivers a received sample |
| link_rx_data | input | 32 | Received sample |
| rx_rd_en | input | 1 | Memory-side read strobe for the receive queue |
| rx_rd_data | output | 32 | Sample most recently read from the receive queue |
| rx_empty | output | 1 | Receive queue holds no samples |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
Results are due at different times, and the checks sample each one at its own time:

- `link_tx_data`, `rx_rd_data` and both error flags are registered. Each reflects a strobe on the edge right after the strobe, so they are compared a quarter period after that edge.
- `tx_full` and `rx_empty` also change on that same edge.
- `reg_rdata` depends only on the current address and the flag registers. It is checked in the same sampling slot against the address driven half a cycle earlier.

A behavioural queue model in the bench updates on every edge from the inputs present before that edge. This lets same-cycle collisions settle in the order the requirements state: a request on an empty queue, a delivery on a full one that is being read, or an error event together with a clearing write.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    localparam int SAMPLE_W     = 32;
    localparam int QUEUE_DEPTH  = 16;
    localparam int REG_ADDR_W   = 8;
    localparam int REG_W        = 32;
    localparam int ERR_BIT      = 4;

    localparam logic [REG_ADDR_W-1:0] OFS_TX_STATUS = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_RX_STATUS = 8'h14;

    typedef struct packed {
        logic tx;
        logic rx;
    } err_pair_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TX   = 2'd1,
        SEL_RX   = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [REG_ADDR_W-1:0] ofs);
        if (ofs == OFS_TX_STATUS)      return SEL_TX;
        else if (ofs == OFS_RX_STATUS) return SEL_RX;
        else                           return SEL_NONE;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic flag);
        logic [REG_W-1:0] w;
        w = '0;
        w[ERR_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[IDX_W-1:0] == rd_ptr[IDX_W-1:0]) &&
                     (wr_ptr[IDX_W] != rd_ptr[IDX_W]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr[IDX_W-1:0]] <= din;
    end

    // R11: the two queue conditions exclude each other
    a_r11_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    // R5 / R9: a push into a full queue leaves the write pointer still
    a_r5_full_push_frozen: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(wr_ptr));
    // R3 / R10: a pop from an empty queue leaves the read pointer still
    a_r3_empty_pop_frozen: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> $stable(rd_ptr));
    // R11: an accepted push always leaves something queued
    a_r11_push_not_empty: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> !empty);
endmodule

// File: rtl/sticky_err_flag.sv
module sticky_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R7: an event wins over a clear in the same cycle
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);
    // R6: a lone clear drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_evt) |=> !flag);
    // R6: with neither input active the flag holds
    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !set_evt) |=> $stable(flag));
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
    import audio_fifo_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int DEPTH  = QUEUE_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_wr_en,
    input  logic [DATA_W-1:0]     tx_wr_data,
    output logic                  tx_full,
    input  logic                  link_tx_req,
    output logic [DATA_W-1:0]     link_tx_data,
    input  logic                  link_rx_valid,
    input  logic [DATA_W-1:0]     link_rx_data,
    input  logic                  rx_rd_en,
    output logic [DATA_W-1:0]     rx_rd_data,
    output logic                  rx_empty,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata
);
    logic [DATA_W-1:0] tx_head, rx_head;
    logic              tx_empty, rx_full;
    err_pair_t         err_set, err_clr, err_q;
    reg_sel_e          wr_sel, rd_sel;

    sample_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst(rst),
        .push(tx_wr_en), .din(tx_wr_data),
        .pop(link_tx_req), .head(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    sample_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst(rst),
        .push(link_rx_valid), .din(link_rx_data),
        .pop(rx_rd_en), .head(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    // Output holding registers: underrun and empty reads keep the old value
    always_ff @(posedge clk) begin
        if (rst) begin
            link_tx_data <= '0;
            rx_rd_data   <= '0;
        end else begin
            if (link_tx_req && !tx_empty) link_tx_data <= tx_head;
            if (rx_rd_en && !rx_empty)    rx_rd_data   <= rx_head;
        end
    end

    assign wr_sel     = decode_offset(reg_addr);
    assign rd_sel     = decode_offset(reg_addr);
    assign err_set.tx = link_tx_req && tx_empty;
    assign err_set.rx = link_rx_valid && rx_full;
    assign err_clr.tx = reg_wr_en && (wr_sel == SEL_TX) && reg_wdata[ERR_BIT];
    assign err_clr.rx = reg_wr_en && (wr_sel == SEL_RX) && reg_wdata[ERR_BIT];

    sticky_err_flag u_tx_err (
        .clk(clk), .rst(rst), .set_evt(err_set.tx), .clr_req(err_clr.tx), .flag(err_q.tx)
    );
    sticky_err_flag u_rx_err (
        .clk(clk), .rst(rst), .set_evt(err_set.rx), .clr_req(err_clr.rx), .flag(err_q.rx)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_TX:  reg_rdata = status_word(err_q.tx);
            SEL_RX:  reg_rdata = status_word(err_q.rx);
            default: reg_rdata = '0;
        endcase
    end

    // R3: an underrun request repeats the previous sample
    a_r3_underrun_repeats: assert property (@(posedge clk) disable iff (rst)
        (link_tx_req && tx_empty) |=> $stable(link_tx_data));
    // R10: reading an empty receive queue holds the read data
    a_r10_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        (rx_rd_en && rx_empty) |=> $stable(rx_rd_data));
    // R8: only the flag bit can ever be non-zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~(REG_W'(1) << ERR_BIT)) == '0);
    // R9: a write into a full transmit queue, without a drain, keeps it full
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (tx_wr_en && tx_full && !link_tx_req) |=> tx_full);
endmodule

// File: tb/audio_fifo_pair_bench.sv
module audio_fifo_pair_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_wr_en, link_tx_req, link_rx_valid, rx_rd_en, reg_wr_en;
    logic [31:0] tx_wr_data, link_rx_data, reg_wdata;
    logic [7:0]  reg_addr;
    logic        tx_full, rx_empty;
    logic [31:0] link_tx_data, rx_rd_data, reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    audio_fifo_pair u_audio_fifo_pair (
        .clk(clk), .rst(rst),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .link_tx_req(link_tx_req), .link_tx_data(link_tx_data),
        .link_rx_valid(link_rx_valid), .link_rx_data(link_rx_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] m_tx_data, m_rx_data;
    logic        m_tx_err, m_rx_err;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rdata(input logic [7:0] a);
        if (a == 8'h10) return {27'd0, m_tx_err, 4'd0};
        if (a == 8'h14) return {27'd0, m_rx_err, 4'd0};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            txq.delete(); rxq.delete();
            m_tx_data = '0; m_rx_data = '0; m_tx_err = 0; m_rx_err = 0;
        end else begin
            int tx_n, rx_n;
            tx_n = txq.size();
            rx_n = rxq.size();
            if (link_tx_req) begin
                if (tx_n > 0) m_tx_data = txq.pop_front();
            end
            if (tx_wr_en && tx_n < DEPTH) txq.push_back(tx_wr_data);
            if (rx_rd_en && rx_n > 0) m_rx_data = rxq.pop_front();
            if (link_rx_valid && rx_n < DEPTH) rxq.push_back(link_rx_data);
            if (link_tx_req && tx_n == 0) m_tx_err = 1;
            else if (reg_wr_en && reg_addr == 8'h10 && reg_wdata[4]) m_tx_err = 0;
            if (link_rx_valid && rx_n == DEPTH) m_rx_err = 1;
            else if (reg_wr_en && reg_addr == 8'h14 && reg_wdata[4]) m_rx_err = 0;
        end
        #(CLK_PERIOD/4);
        if (!rst) begin
            chk("R2 R3 link_tx_data", link_tx_data, m_tx_data);
            chk("R4 R10 rx_rd_data", rx_rd_data, m_rx_data);
            chk("R11 R9 tx_full", {31'd0, tx_full}, {31'd0, txq.size() == DEPTH});
            chk("R11 rx_empty", {31'd0, rx_empty}, {31'd0, rxq.size() == 0});
            chk("R6 R8 reg_rdata", reg_rdata, model_rdata(reg_addr));
        end
    end

    task automatic idle();
        tx_wr_en = 0; link_tx_req = 0; link_rx_valid = 0; rx_rd_en = 0; reg_wr_en = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        idle(); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1; idle(); tx_wr_data = 0; link_rx_data = 0; reg_wdata = 0; reg_addr = 0;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        read_reg(8'h10, 32'd0, "R1 tx status");
        read_reg(8'h14, 32'd0, "R1 rx status");
        chk("R1 link_tx_data", link_tx_data, 32'd0);
        chk("R1 rx_rd_data", rx_rd_data, 32'd0);
        chk("R1 tx_full", {31'd0, tx_full}, 32'd0);
        chk("R1 rx_empty", {31'd0, rx_empty}, 32'd1);

        // R3 underrun before any sample: zero output, flag set
        link_tx_req = 1; step(); idle();
        chk("R3 first underrun data", link_tx_data, 32'd0);
        read_reg(8'h10, 32'h10, "R3 tx flag set");
        read_reg(8'h14, 32'h0, "R8 rx flag untouched");

        // R6 write 0 in bit 4 keeps flag, other offset ignored
        reg_wr_en = 1; reg_addr = 8'h10; reg_wdata = 32'hFFFF_FFEF; step(); idle();
        read_reg(8'h10, 32'h10, "R6 zero bit keeps");
        reg_wr_en = 1; reg_addr = 8'h18; reg_wdata = 32'hFFFF_FFFF; step(); idle();
        read_reg(8'h10, 32'h10, "R6 other offset ignored");
        read_reg(8'h18, 32'h0, "R8 unmapped reads zero");
        reg_wr_en = 1; reg_addr = 8'h10; reg_wdata = 32'h10; step(); idle();
        read_reg(8'h10, 32'h0, "R6 clear");

        // R2 order, then R3 repeat of last sample
        for (int i = 0; i < 3; i++) begin
            tx_wr_en = 1; tx_wr_data = 32'hA000_0000 + i; step();
        end
        idle();
        for (int i = 0; i < 3; i++) begin
            link_tx_req = 1; step(); idle();
            chk("R2 tx order", link_tx_data, 32'hA000_0000 + i);
        end
        link_tx_req = 1; step(); step(); idle();
        chk("R3 repeat last", link_tx_data, 32'hA000_0002);
        tx_wr_en = 1; tx_wr_data = 32'hBEEF; step(); idle();
        link_tx_req = 1; step(); idle();
        chk("R3 pointer kept", link_tx_data, 32'hBEEF);

        // R7 event and clear together
        link_tx_req = 1; reg_wr_en = 1; reg_addr = 8'h10; reg_wdata = 32'h10; step(); idle();
        read_reg(8'h10, 32'h10, "R7 set wins");
        reg_wr_en = 1; reg_addr = 8'h10; reg_wdata = 32'h10; step(); idle();

        // R9 / R11 fill transmit queue beyond depth
        for (int i = 0; i < DEPTH + 2; i++) begin
            tx_wr_en = 1; tx_wr_data = 32'hC000_0000 + i; step();
        end
        idle();
        chk("R11 tx_full", {31'd0, tx_full}, 32'd1);
        read_reg(8'h10, 32'h0, "R9 no flag on full write");
        for (int i = 0; i < DEPTH; i++) begin
            link_tx_req = 1; step(); idle();
            chk("R9 drained order", link_tx_data, 32'hC000_0000 + i);
        end

        // R10 empty read holds
        rx_rd_en = 1; step(); idle();
        chk("R10 empty read", rx_rd_data, 32'd0);
        read_reg(8'h14, 32'h0, "R10 no flag");

        // R5 overrun, with a read in the same cycle at full
        for (int i = 0; i < DEPTH; i++) begin
            link_rx_valid = 1; link_rx_data = 32'hD000_0000 + i; step();
        end
        link_rx_valid = 1; link_rx_data = 32'hDEAD; rx_rd_en = 1; step(); idle();
        read_reg(8'h14, 32'h10, "R5 rx flag set");
        chk("R4 first rx", rx_rd_data, 32'hD000_0000);
        for (int i = 1; i < DEPTH; i++) begin
            rx_rd_en = 1; step(); idle();
            chk("R4 R5 rx order", rx_rd_data, 32'hD000_0000 + i);
        end
        rx_rd_en = 1; step(); idle();
        chk("R5 dropped sample absent", rx_rd_data, 32'hD000_000F);
        reg_wr_en = 1; reg_addr = 8'h14; reg_wdata = 32'h10; step(); idle();
        read_reg(8'h14, 32'h0, "R6 rx clear");

        // Mixed random traffic, compared every clock by the model
        for (int i = 0; i < 3000; i++) begin
            tx_wr_en      = ($urandom % 3) != 0;
            tx_wr_data    = $urandom;
            link_tx_req   = ($urandom % 3) == 0;
            link_rx_valid = ($urandom % 3) != 0;
            link_rx_data  = $urandom;
            rx_rd_en      = ($urandom % 3) == 0;
            reg_wr_en     = ($urandom % 8) == 0;
            reg_addr      = ($urandom % 2) ? 8'h10 : (($urandom % 2) ? 8'h14 : 8'h0C);
            reg_wdata     = $urandom;
            step();
        end
        idle();
        step(); step();
        summary();
    end
endmodule